// File: doc/BRIEF.md
# GPIO Port with Level Alarms

A bidirectional general-purpose I/O port of parameterised width (1 to 32 bits). Each bit has a direction flag, and the output level comes from an output shadow register. Software never writes these registers whole. It changes them only through masked commands: one drives the masked shadow bits high, one drives them low, one turns the masked bits into inputs, and one turns them into outputs. A zero in the mask always leaves that bit as it was, so two agents that touch different bits never need a read-modify-write sequence.

Each bit can also be armed to watch for a level. A high watch fires while the synchronised pin is 1, and a low watch fires while it is 0. All bits share one registered interrupt line, which is high while any armed condition holds. The bus is a single-cycle command strobe that carries a 4-bit command code and a 32-bit mask. Commands that return a value update a registered read-data output on the clock edge that accepts them.

Top module: `gpa_port`

## Requirements
- R1: After reset every bit is an input (`pad_oe` all 0), `pad_out` is 0, no watch is armed, `alarm_irq` is 0 and `rd_data` is 0.
- R2: Command code 1 (shadow set) drives to 1 every shadow bit whose mask bit is 1 and leaves every other bit unchanged. `pad_out` shows the new value after the accepting edge.
- R3: Command code 2 (shadow clear) drives to 0 every shadow bit whose mask bit is 1 and leaves every other bit unchanged.
- R4: Command code 7 (make output) sets the direction flag (1 = output, driving `pad_oe`) of every masked bit and leaves unmasked bits unchanged. `rd_data` then holds the mask of all bits that are outputs after the change.
- R5: Command code 6 (make input) clears the direction flag of every masked bit and leaves unmasked bits unchanged. `rd_data` then holds the mask of all bits that are inputs after the change.
- R6: Command code 3 (arm high) arms a high-level watch on each masked bit. The other watches are unchanged.
- R7: Command code 4 (arm low) arms a low-level watch on each masked bit. The other watches are unchanged.
- R8: Command code 5 (disarm) removes both the high and the low watch from each masked bit.
- R9: `alarm_irq` equals, one cycle later, the OR over all bits of (high watch AND pin 1) OR (low watch AND pin 0), using the synchronised pin. A pad change reaches `alarm_irq` on the third rising edge after it.
- R10: Command code 8 returns the two-flop-synchronised pad levels, and code 9 returns the output shadow. Both are zero-extended to 32 bits in `rd_data`.
- R11: Mask bits at or above the port width, codes 0 and 10 to 15, and cycles with `cmd_valid` low change no state.
- R12: `rd_data` changes only on codes 6, 7, 8 and 9 and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_code | input | 4 | Command code |
| cmd_mask | input | 32 | Bit mask for the command |
| rd_data | output | 32 | Registered read-back value |
| pad_in | input | WIDTH | Pad input levels (asynchronous) |
| pad_out | output | WIDTH | Output shadow driven to the pads |
| pad_oe | output | WIDTH | Pad output enables, 1 = drive |
| alarm_irq | output | 1 | Registered level-alarm interrupt |

## Verification
The hardest situation to reach is the interrupt timing. It depends on both the armed watches and pad levels that pass through a synchronizer, and a watch armed high and low on the same bit fires whatever the pin level is. The bench holds each pad pattern steady through the synchronizer delay before it issues commands. It then sweeps a deterministic sequence of codes and masks over an 8-bit port against an arithmetic model, and it checks the interrupt on the edge after each command. A separate sequence arms one bit, toggles its pad, and samples `alarm_irq` on the second and third edges to pin down the three-edge latency.

// File: rtl/gpa_pkg.sv
package gpa_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CMD_NOP       = 4'd0,
    CMD_OUT_SET   = 4'd1,
    CMD_OUT_CLR   = 4'd2,
    CMD_ARM_HI    = 4'd3,
    CMD_ARM_LO    = 4'd4,
    CMD_DISARM    = 4'd5,
    CMD_DIR_IN    = 4'd6,
    CMD_DIR_OUT   = 4'd7,
    CMD_RD_PINS   = 4'd8,
    CMD_RD_SHADOW = 4'd9
  } gpa_cmd_e;
endpackage

// File: rtl/gpa_rst_sync.sv
module gpa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpa_in_sync.sv
module gpa_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_async;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpa_ctrl.sv
module gpa_ctrl
  import gpa_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [CODE_W-1:0]  cmd_code,
  input  logic [BUS_W-1:0]   cmd_mask,
  input  logic [WIDTH-1:0]   pins_sync,
  output logic [WIDTH-1:0]   shadow_q,
  output logic [WIDTH-1:0]   dir_q,
  output logic [WIDTH-1:0]   arm_hi_q,
  output logic [WIDTH-1:0]   arm_lo_q,
  output logic [BUS_W-1:0]   rd_data_q
);
  logic [WIDTH-1:0] mask_w;
  logic             unused_mask_bits;
  logic [WIDTH-1:0] shadow_d, dir_d, arm_hi_d, arm_lo_d;
  logic             shadow_en, dir_en, arm_hi_en, arm_lo_en, rd_en;
  logic [BUS_W-1:0] rd_d;
  gpa_cmd_e         code;

  assign mask_w           = cmd_mask[WIDTH-1:0];
  assign unused_mask_bits = ^cmd_mask;
  assign code             = gpa_cmd_e'(cmd_code);

  always_comb begin
    shadow_en = 1'b0;
    dir_en    = 1'b0;
    arm_hi_en = 1'b0;
    arm_lo_en = 1'b0;
    rd_en     = 1'b0;
    shadow_d  = shadow_q;
    dir_d     = dir_q;
    arm_hi_d  = arm_hi_q;
    arm_lo_d  = arm_lo_q;
    rd_d      = '0;
    if (cmd_valid) begin
      case (code)
        CMD_OUT_SET: begin
          shadow_en = 1'b1;
          shadow_d  = shadow_q | mask_w;
        end
        CMD_OUT_CLR: begin
          shadow_en = 1'b1;
          shadow_d  = shadow_q & ~mask_w;
        end
        CMD_ARM_HI: begin
          arm_hi_en = 1'b1;
          arm_hi_d  = arm_hi_q | mask_w;
        end
        CMD_ARM_LO: begin
          arm_lo_en = 1'b1;
          arm_lo_d  = arm_lo_q | mask_w;
        end
        CMD_DISARM: begin
          arm_hi_en = 1'b1;
          arm_lo_en = 1'b1;
          arm_hi_d  = arm_hi_q & ~mask_w;
          arm_lo_d  = arm_lo_q & ~mask_w;
        end
        CMD_DIR_IN: begin
          dir_en = 1'b1;
          rd_en  = 1'b1;
          dir_d  = dir_q & ~mask_w;
          rd_d[WIDTH-1:0] = ~dir_d;
        end
        CMD_DIR_OUT: begin
          dir_en = 1'b1;
          rd_en  = 1'b1;
          dir_d  = dir_q | mask_w;
          rd_d[WIDTH-1:0] = dir_d;
        end
        CMD_RD_PINS: begin
          rd_en = 1'b1;
          rd_d[WIDTH-1:0] = pins_sync;
        end
        CMD_RD_SHADOW: begin
          rd_en = 1'b1;
          rd_d[WIDTH-1:0] = shadow_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      dir_q     <= '0;
      arm_hi_q  <= '0;
      arm_lo_q  <= '0;
      rd_data_q <= '0;
    end else begin
      if (shadow_en) shadow_q  <= shadow_d;
      if (dir_en)    dir_q     <= dir_d;
      if (arm_hi_en) arm_hi_q  <= arm_hi_d;
      if (arm_lo_en) arm_lo_q  <= arm_lo_d;
      if (rd_en)     rd_data_q <= rd_d;
    end
  end

  // R2
  shadow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && code == CMD_OUT_SET) |=> ((shadow_q & $past(mask_w)) == $past(mask_w)));
  // R3
  shadow_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && code == CMD_OUT_CLR) |=> ((shadow_q & $past(mask_w)) == '0));
  // R5
  dir_in_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && code == CMD_DIR_IN) |=>
      ((dir_q & ~$past(mask_w)) == ($past(dir_q) & ~$past(mask_w))));
  // R8
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && code == CMD_DISARM) |=> (((arm_hi_q | arm_lo_q) & $past(mask_w)) == '0));
  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && (code == CMD_DIR_IN || code == CMD_DIR_OUT ||
                    code == CMD_RD_PINS || code == CMD_RD_SHADOW)) |=> $stable(rd_data_q));
endmodule

// File: rtl/gpa_alarm.sv
module gpa_alarm #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_sync,
  input  logic [WIDTH-1:0] arm_hi,
  input  logic [WIDTH-1:0] arm_lo,
  output logic             irq_q
);
  logic [WIDTH-1:0] hit;
  logic             irq_d;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      assign hit[b] = (arm_hi[b] & pins_sync[b]) | (arm_lo[b] & ~pins_sync[b]);
    end
  endgenerate

  always_comb irq_d = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R9
  no_arm_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_hi | arm_lo) == '0) |=> !irq_q);
  // R9
  both_arm_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_hi & arm_lo) != '0) |=> irq_q);
endmodule

// File: rtl/gpa_port.sv
module gpa_port
  import gpa_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [31:0]       cmd_mask,
  output logic [31:0]       rd_data,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic              alarm_irq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic             rst_int_n;
  logic [WIDTH-1:0] pins_sync, shadow, dir, arm_hi, arm_lo;

  initial begin
    if (WIDTH < 1 || WIDTH > BUS_W) $error("gpa_port: WIDTH out of range");
  end

  gpa_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  gpa_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_async(pad_in), .q_sync(pins_sync));

  gpa_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_mask(cmd_mask), .pins_sync(pins_sync), .shadow_q(shadow), .dir_q(dir),
    .arm_hi_q(arm_hi), .arm_lo_q(arm_lo), .rd_data_q(rd_data));

  gpa_alarm #(.WIDTH(WIDTH)) u_alarm (
    .clk(clk), .rst_n(rst_int_n), .pins_sync(pins_sync), .arm_hi(arm_hi),
    .arm_lo(arm_lo), .irq_q(alarm_irq));

  assign pad_out = shadow;
  assign pad_oe  = dir;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_int_n |-> (pad_oe == '0 && pad_out == '0 && !alarm_irq));
endmodule

// File: tb/gpa_port_tb.sv
module gpa_port_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [31:0] cmd_mask = '0;
  logic [31:0] rd_data;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;
  logic alarm_irq;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_sh = '0, m_dir = '0, m_hi = '0, m_lo = '0;
  logic [31:0] m_rd = '0;

  always #10 clk = ~clk;

  gpa_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_mask(cmd_mask), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .alarm_irq(alarm_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return |((m_hi & pad_in) | (m_lo & ~pad_in));
  endfunction

  task automatic set_pins(input logic [W-1:0] p);
    @(negedge clk); pad_in = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [3:0] c, input logic [31:0] m);
    logic [W-1:0] mw = m[W-1:0];
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = c; cmd_mask = m;
    case (c)
      4'd1: m_sh = m_sh | mw;
      4'd2: m_sh = m_sh & ~mw;
      4'd3: m_hi = m_hi | mw;
      4'd4: m_lo = m_lo | mw;
      4'd5: begin m_hi = m_hi & ~mw; m_lo = m_lo & ~mw; end
      4'd6: begin m_dir = m_dir & ~mw; m_rd = {24'd0, ~m_dir}; end
      4'd7: begin m_dir = m_dir | mw; m_rd = {24'd0, m_dir}; end
      4'd8: m_rd = {24'd0, pad_in};
      4'd9: m_rd = {24'd0, m_sh};
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2/R3 pad_out", {24'd0, pad_out}, {24'd0, m_sh});
    chk("R4/R5 pad_oe", {24'd0, pad_oe}, {24'd0, m_dir});
    chk("R10/R12 rd_data", rd_data, m_rd);
    @(negedge clk);
    chk("R9 alarm_irq", {31'd0, alarm_irq}, {31'd0, exp_irq()});
  endtask

  initial begin
    #2000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", {24'd0, pad_oe}, 32'd0);
    chk("R1 pad_out", {24'd0, pad_out}, 32'd0);
    chk("R1 irq", {31'd0, alarm_irq}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);

    // R9 latency: arm high on bit 0 with pins low, then raise pin 0
    set_pins('0);
    do_cmd(4'd3, 32'h1);
    @(negedge clk); pad_in = 8'h01;
    @(negedge clk);
    @(negedge clk);
    chk("R9 irq before third edge", {31'd0, alarm_irq}, 32'd0);
    @(negedge clk);
    chk("R9 irq on third edge", {31'd0, alarm_irq}, 32'd1);
    do_cmd(4'd5, 32'hFF);

    // R6/R7 both watches on one bit fire regardless of level
    do_cmd(4'd3, 32'h80);
    do_cmd(4'd4, 32'h80);
    set_pins(8'h00);
    chk("R6/R7 irq low pin", {31'd0, alarm_irq}, 32'd1);
    set_pins(8'h80);
    chk("R6/R7 irq high pin", {31'd0, alarm_irq}, 32'd1);
    do_cmd(4'd5, 32'h80);
    chk("R8 disarmed", {31'd0, alarm_irq}, 32'd0);

    // R11 upper mask bits and unused codes
    do_cmd(4'd1, 32'hFFFF_FF00);
    do_cmd(4'd7, 32'hABCD_0000);
    for (int c = 10; c < 16; c++) do_cmd(c[3:0], 32'hFFFF_FFFF);
    do_cmd(4'd0, 32'hFFFF_FFFF);
    chk("R11 no change", {16'd0, pad_out, pad_oe}, {16'd0, m_sh, m_dir});

    // Sweep of codes and masks against the model
    for (int i = 0; i < 600; i++) begin
      if (i % 5 == 0) set_pins(W'((i * 73 + 5) & 255));
      do_cmd(4'((i * 7) % 10), 32'((i * 37 + 11) & 255) | (32'(i) << 8));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule